// File: doc/BRIEF.md
# Interrupt Request Input Conditioner

This block sits between the raw interrupt pins of a processor and its interrupt controller. It brings one non-maskable request line and a set of maskable request lines into the core clock domain. It then turns each line into a clean pending flag that the controller can read on every cycle.

The non-maskable line is sensitive to rising edges only and cannot be masked. Once an edge is seen it is held in a latch until the core reaches an instruction boundary. In that cycle the block flags the take and presents the fixed type code 2. Each maskable line has its own configuration bit that selects edge sensing or level sensing. An edge-sensed flag is held until the core acknowledges that line. A level-sensed flag simply tracks the synchronized pin.

The two upper request lines can each be given a second job: they become active-low acknowledge outputs for the two lowest lines. While a line is used this way, its own request flag is held at zero.

Top module: `irq_conditioner`

## Requirements
- R1: After synchronous reset, `nmi_pend`, `nmi_take` and every bit of `req_pend` are 0, `nmi_vec` is 0, and both bits of `ack_n_out` are 1.
- R2: A pin change must pass through two synchronizer flops and the flag register before it shows on a flag. A pin driven high before clock edge N shows on its flag after edge N+2, and not after edge N+1.
- R3: A rising edge on `nmi_pin` sets `nmi_pend`, even when the pin is high for only one clock. The flag then stays set until an instruction boundary, whatever the pin does afterwards.
- R4: In a cycle where `nmi_pend` is 1 and `instr_boundary` is 1, `nmi_take` is 1 and `nmi_vec` equals 2. After that edge `nmi_pend` is 0. The exception is a new non-maskable edge detected in the same cycle: then `nmi_pend` stays 1.
- R5: A line with `cfg_level[i]`=0 is edge-sensed. A rising edge sets `req_pend[i]`, and the flag stays set after the pin falls, until a cycle with `ack[i]`=1 clears it. If a new rising edge is detected in the same cycle as the acknowledge, the flag stays set.
- R6: A line with `cfg_level[i]`=1 is level-sensed. `req_pend[i]` equals the synchronized pin, and `ack[i]` has no effect on it.
- R7: An edge-sensed flag is set only by a low-to-high transition. A pin that stays high after being acknowledged does not set the flag again.
- R8: When `cfg_ack_en[k]`=1 (k=0,1), line k+2 is an acknowledge output for line k. `ack_n_out[k]` is 0 in exactly the cycles where `ack[k]`=1, and 1 in all other cycles. `req_pend[k+2]` reads 0 whatever is on its pin. When `cfg_ack_en[k]`=0, `ack_n_out[k]` is 1.
- R9: `nmi_vec` is 0 in every cycle in which `nmi_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Raw non-maskable request, rising-edge sensitive |
| req_pin | input | NUM_REQ | Raw maskable requests, active high |
| cfg_level | input | NUM_REQ | Per line: 1 = level sensing, 0 = edge sensing |
| cfg_ack_en | input | 2 | Bit k turns line k+2 into the acknowledge output for line k |
| ack | input | NUM_REQ | Acknowledge strobes from the core, one per line |
| instr_boundary | input | 1 | Core is at an instruction boundary this cycle |
| nmi_pend | output | 1 | Latched non-maskable request |
| nmi_take | output | 1 | Non-maskable request is taken this cycle |
| nmi_vec | output | TYPE_W | Type code of the taken non-maskable request, else 0 |
| req_pend | output | NUM_REQ | Pending flags of the maskable lines |
| ack_n_out | output | 2 | Active-low acknowledge outputs for lines 0 and 1 |

## Verification
Two pairs of events can land in the same cycle, and both are provoked on purpose. The first pair is a newly detected rising edge on an edge-sensed line and the acknowledge for that same line. The second is a fresh non-maskable edge and an instruction boundary that takes the request already latched. In both cases the bench re-pulses the pin and asserts the strobe exactly two clock edges later, which is the cycle in which the synchronized edge is visible inside the block. It then requires the flag to still read 1 on the next cycle. A second strobe, given alone, must then clear the flag, which shows that the first strobe was actually applied.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    localparam int NUM_REQ_DEF  = 4;
    localparam int SYNC_STAGES  = 2;
    localparam int TYPE_W_DEF   = 8;
    localparam int NMI_TYPE_DEF = 2;
    localparam int ACK_PAIRS    = 2;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   force_off;
    } line_cfg_t;

    function automatic line_cfg_t make_cfg(input logic level_bit, input logic as_ack);
        line_cfg_t c;
        c.sense     = level_bit ? SENSE_LEVEL : SENSE_EDGE;
        c.force_off = as_ack;
        return c;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~hist_q;

    p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              boundary_i,
    output logic              pend_o,
    output logic              take_o,
    output logic [TYPE_W-1:0] vec_o
);
    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= rise_i | (latch_q & ~boundary_i);
    end

    assign pend_o = latch_q;
    assign take_o = latch_q & boundary_i;
    assign vec_o  = take_o ? TYPE_W'(NMI_TYPE) : '0;

    p_nmi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !boundary_i) |=> pend_o);

    p_nmi_edge_r3: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> pend_o);

    p_nmi_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (take_o && !rise_i) |=> !pend_o);

    p_nmi_vec_r9: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vec_o == '0));

endmodule

// File: rtl/irq_req_line.sv
module irq_req_line
    import irq_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_cfg_t cfg_i,
    input  logic      sync_i,
    input  logic      rise_i,
    input  logic      ack_i,
    output logic      pend_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (cfg_i.force_off) begin
            flag_q <= 1'b0;
        end else begin
            case (cfg_i.sense)
                SENSE_LEVEL: flag_q <= sync_i;
                default:     flag_q <= rise_i | (flag_q & ~ack_i);
            endcase
        end
    end

    assign pend_o = flag_q;

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sense == SENSE_EDGE && !cfg_i.force_off && flag_q && !ack_i)
        |=> (flag_q || cfg_i.sense == SENSE_LEVEL || cfg_i.force_off));

    p_edge_ack_race_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sense == SENSE_EDGE && !cfg_i.force_off && rise_i && ack_i) |=> flag_q);

    p_level_ack_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sense == SENSE_LEVEL && !cfg_i.force_off && sync_i && ack_i) |=> flag_q);

endmodule

// File: rtl/irq_conditioner.sv
module irq_conditioner
    import irq_cond_pkg::*;
#(
    parameter int NUM_REQ  = NUM_REQ_DEF,
    parameter int TYPE_W   = TYPE_W_DEF,
    parameter int NMI_TYPE = NMI_TYPE_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nmi_pin,
    input  logic [NUM_REQ-1:0]   req_pin,
    input  logic [NUM_REQ-1:0]   cfg_level,
    input  logic [ACK_PAIRS-1:0] cfg_ack_en,
    input  logic [NUM_REQ-1:0]   ack,
    input  logic                 instr_boundary,
    output logic                 nmi_pend,
    output logic                 nmi_take,
    output logic [TYPE_W-1:0]    nmi_vec,
    output logic [NUM_REQ-1:0]   req_pend,
    output logic [ACK_PAIRS-1:0] ack_n_out
);
    localparam int ALL_W    = NUM_REQ + 1;
    localparam int ACK_BASE = NUM_REQ - ACK_PAIRS;

    logic [ALL_W-1:0] raw_all, sync_all, rise_all;

    assign raw_all = {req_pin, nmi_pin};

    irq_sync #(.W(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_all),
        .sync_o (sync_all),
        .rise_o (rise_all)
    );

    irq_nmi_latch #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_nmi (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise_all[0]),
        .boundary_i (instr_boundary),
        .pend_o     (nmi_pend),
        .take_o     (nmi_take),
        .vec_o      (nmi_vec)
    );

    line_cfg_t line_cfg [NUM_REQ];

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
        if (i >= ACK_BASE) begin : g_shared
            assign line_cfg[i] = make_cfg(cfg_level[i], cfg_ack_en[i-ACK_BASE]);
        end else begin : g_plain
            assign line_cfg[i] = make_cfg(cfg_level[i], 1'b0);
        end

        irq_req_line u_line (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (line_cfg[i]),
            .sync_i (sync_all[i+1]),
            .rise_i (rise_all[i+1]),
            .ack_i  (ack[i]),
            .pend_o (req_pend[i])
        );
    end

    for (genvar k = 0; k < ACK_PAIRS; k++) begin : g_ackout
        assign ack_n_out[k] = ~(cfg_ack_en[k] & ack[k]);

        p_ack_low_r8: assert property (@(posedge clk) disable iff (rst)
            (cfg_ack_en[k] && ack[k]) |-> !ack_n_out[k]);

        p_ack_idle_r8: assert property (@(posedge clk) disable iff (rst)
            !(cfg_ack_en[k] && ack[k]) |-> ack_n_out[k]);

        p_forced_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (cfg_ack_en[k] && $past(cfg_ack_en[k])) |-> !req_pend[ACK_BASE+k]);
    end

    p_take_vec_r4: assert property (@(posedge clk) disable iff (rst)
        nmi_take |-> (nmi_pend && nmi_vec == TYPE_W'(NMI_TYPE)));

endmodule

// File: tb/test_irq_conditioner.sv
module test_irq_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       nmi_pin;
    logic [N-1:0] req_pin, cfg_level, ack, req_pend;
    logic [1:0] cfg_ack_en, ack_n_out;
    logic       instr_boundary, nmi_pend, nmi_take;
    logic [7:0] nmi_vec;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_conditioner i_irq_conditioner (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .req_pin(req_pin),
        .cfg_level(cfg_level), .cfg_ack_en(cfg_ack_en), .ack(ack),
        .instr_boundary(instr_boundary), .nmi_pend(nmi_pend),
        .nmi_take(nmi_take), .nmi_vec(nmi_vec), .req_pend(req_pend),
        .ack_n_out(ack_n_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; nmi_pin = 0; req_pin = 0; cfg_level = 0; ack = 0;
        cfg_ack_en = 0; instr_boundary = 0;
        tick(3);
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 nmi_pend", nmi_pend, 0);
        chk("R1 nmi_take", nmi_take, 0);
        chk("R1 nmi_vec", nmi_vec, 0);
        chk("R1 req_pend", req_pend, 0);
        chk("R1 ack_n_out", ack_n_out, 2'b11);
    endtask

    task automatic t_nmi_pulse();
        do_reset();
        nmi_pin = 1; tick(1); nmi_pin = 0;
        tick(1);
        chk("R2 nmi not yet", nmi_pend, 0);
        tick(1);
        chk("R3 nmi latched", nmi_pend, 1);
        tick(5);
        chk("R3 nmi held", nmi_pend, 1);
        chk("R9 vec idle", nmi_vec, 0);
        instr_boundary = 1; #1;
        chk("R4 take", nmi_take, 1);
        chk("R4 vec", nmi_vec, 2);
        tick(1); instr_boundary = 0; #1;
        chk("R4 cleared", nmi_pend, 0);
    endtask

    task automatic t_nmi_race();
        do_reset();
        nmi_pin = 1; tick(1); nmi_pin = 0; tick(4);
        nmi_pin = 1; tick(1); nmi_pin = 0; tick(1);
        instr_boundary = 1; #1;
        chk("R4 take in race", nmi_take, 1);
        tick(1); instr_boundary = 0; #1;
        chk("R4 new edge kept", nmi_pend, 1);
        instr_boundary = 1; tick(1); instr_boundary = 0; #1;
        chk("R4 second take clears", nmi_pend, 0);
    endtask

    task automatic t_edge_mode();
        do_reset();
        req_pin[0] = 1; tick(2);
        chk("R2 edge not yet", req_pend[0], 0);
        tick(1);
        chk("R5 edge set", req_pend[0], 1);
        req_pin[0] = 0; tick(4);
        chk("R5 held after fall", req_pend[0], 1);
        ack[0] = 1; tick(1); ack[0] = 0; #1;
        chk("R5 ack clears", req_pend[0], 0);
        req_pin[1] = 1; tick(4);
        ack[1] = 1; tick(1); ack[1] = 0; tick(4);
        chk("R7 held high no reset", req_pend[1], 0);
        req_pin[1] = 0; tick(4);
        chk("R7 fall no set", req_pend[1], 0);
    endtask

    task automatic t_edge_ack_race();
        do_reset();
        req_pin[0] = 1; tick(1); req_pin[0] = 0; tick(5);
        req_pin[0] = 1; tick(1); req_pin[0] = 0; tick(1);
        ack[0] = 1; tick(1); ack[0] = 0; #1;
        chk("R5 edge wins over ack", req_pend[0], 1);
        ack[0] = 1; tick(1); ack[0] = 0; #1;
        chk("R5 lone ack clears", req_pend[0], 0);
    endtask

    task automatic t_level_mode();
        do_reset();
        cfg_level[2] = 1;
        req_pin[2] = 1; tick(3);
        chk("R6 level high", req_pend[2], 1);
        ack[2] = 1; tick(1); ack[2] = 0; #1;
        chk("R6 ack ignored", req_pend[2], 1);
        req_pin[2] = 0; tick(2);
        chk("R6 not yet low", req_pend[2], 1);
        tick(1);
        chk("R6 follows low", req_pend[2], 0);
    endtask

    task automatic t_ack_mode();
        do_reset();
        cfg_ack_en = 2'b11; cfg_level[3] = 1;
        req_pin[2] = 1; req_pin[3] = 1; tick(5);
        chk("R8 forced zero", req_pend[3:2], 0);
        ack[0] = 1; #1;
        chk("R8 ack0 low", ack_n_out, 2'b10);
        tick(1); ack[0] = 0; ack[1] = 1; #1;
        chk("R8 ack1 low", ack_n_out, 2'b01);
        tick(1); ack[1] = 0; #1;
        chk("R8 idle high", ack_n_out, 2'b11);
        cfg_ack_en = 2'b00; ack[0] = 1; #1;
        chk("R8 disabled high", ack_n_out, 2'b11);
        ack[0] = 0;
        tick(1);
        chk("R6 line3 level restored", req_pend[3], 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_nmi_pulse();
                t_nmi_race();
                t_edge_mode();
                t_edge_ack_race();
                t_level_mode();
                t_ack_mode();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule